// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block is the digital control core of a successive-approximation converter. It takes a conversion-start strobe that is active low and arrives with no fixed phase relation to the converter clock. The strobe first passes through a synchroniser. The block then accepts the strobe only if it stays low long enough. While the accepted strobe is still low, the block drives a busy flag. When the strobe is released, it switches the track/hold control into hold, and it then times the conversion.

The conversion length is not fixed. A nominal run takes a set number of converter clocks. Each clock in which the host flags a bus access inside a clock-low window becomes a slip cycle, which adds one clock. The number of slip cycles per conversion is capped.

The successive-approximation register is modelled digitally. It works against a test value that is captured when the conversion starts, and it resolves one bit per step, most significant bit first. At the end of the run the block pulses a done strobe and presents the result word. A start request that arrives while a conversion is running is discarded and sets a sticky overrun flag, which a status read clears.

Top module: `adc_conv_seq`

## Requirements
- R1: `startN` passes through a two-stage synchroniser. When a qualified low pulse is released, `holdEn` rises at the third rising clock edge after the release.
- R2: A start pulse qualifies only if the synchronised `startN` is seen low on at least two consecutive clocks after a high-to-low transition. A pulse that is low for one clock is rejected: no hold and no busy.
- R3: `busyN` is driven low from qualification until `startN` is released, and is high in every other state. `busyN` is never low while `holdEn` is high. `holdEn` is 1 for hold and 0 for track.
- R4: With no slip cycles, `holdEn` stays high for exactly 56 clocks.
- R5: Each clock during hold in which `hostSlip` is 1 adds one clock to the conversion, up to 17 slip cycles, so hold lasts at most 73 clocks. `hostSlip` has no effect outside hold.
- R6: `done` is a one-clock pulse in the first clock after `holdEn` falls. At that point `result` holds the unsigned 12-bit word produced by bit-by-bit trials from the most significant bit down. This word equals the captured sample, and it stays on `result` after the pulse.
- R7: `sampleIn` is captured on the clock in which hold begins. Later changes to `sampleIn` do not alter the result.
- R8: A high-to-low transition of the synchronised `startN` during hold does not change the conversion length and sets `overrun`. `overrun` stays set until a clock with `statusRead` high clears it.
- R9: A `startN` that is still low when a conversion ends does not start a new conversion. A fresh high-to-low transition is required.
- R10: During reset, `busyN`=1, `holdEn`=0, `done`=0, `result`=0 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startN | input | 1 | Asynchronous conversion-start strobe, active low |
| hostSlip | input | 1 | Host access landed in a clock-low window this clock |
| statusRead | input | 1 | Status read strobe; clears the overrun flag |
| sampleIn | input | 12 | Test input value for the digital model of the successive-approximation register |
| busyN | output | 1 | Busy flag, active low |
| holdEn | output | 1 | Track/hold control (1 = hold) |
| done | output | 1 | One-clock conversion-complete pulse |
| result | output | 12 | Converted word |
| overrun | output | 1 | Sticky flag: a start request arrived during a conversion |

## Verification
A bad conversion counter or a miscounted slip shows up as a hold window of the wrong length, and `done` then arrives early or late on the very conversion affected. A wrong bit pointer or a wrong trial comparison shows up as a wrong `result` at the next `done`. Sweeping sample values across the whole range exposes this within one conversion. A wrong qualifier or a wrong synchroniser depth shifts the rise of `holdEn` by whole clocks, or lets a one-clock pulse through, within a few clocks of the strobe. An overrun flag that is not sticky, or not cleared, shows on the next status read.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ARM  = 2'd1,
    SEQ_CONV = 2'd2
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic step;
    logic finish;
  } seqStrobes_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CLKS   = 56,
  parameter int MAX_SLIP    = 17,
  parameter int MIN_LOW     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startN,
  input  logic        hostSlip,
  input  logic        statusRead,
  output logic        busyN,
  output logic        holdEn,
  output logic        overrun,
  output seqStrobes_t strobes
);

  localparam int CNT_W  = $clog2(CONV_CLKS);
  localparam int SLIP_W = $clog2(MAX_SLIP + 1);
  localparam int LOW_W  = $clog2(MIN_LOW + 1);
  localparam int LEN_W  = $clog2(CONV_CLKS + MAX_SLIP + 1);
  localparam logic [CNT_W-1:0]  LAST_CNT   = CNT_W'(CONV_CLKS - 1);
  localparam logic [CNT_W-1:0]  FIRST_STEP = CNT_W'(CONV_CLKS - DATA_W);
  localparam logic [LOW_W-1:0]  LOW_QUAL   = LOW_W'(MIN_LOW - 1);
  localparam logic [SLIP_W-1:0] SLIP_CAP   = SLIP_W'(MAX_SLIP);
  localparam logic [LEN_W-1:0]  LEN_LAST   = LEN_W'(CONV_CLKS + MAX_SLIP - 1);

  // start strobe synchroniser
  logic [SYNC_STAGES-1:0] syncQ;
  logic sLvl, sPrev, fellEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      sPrev <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], startN};
      sPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign sLvl     = syncQ[SYNC_STAGES-1];
  assign fellEdge = !sLvl && sPrev;

  seqState_t         state, stateNext;
  logic [LOW_W-1:0]  lowCnt;
  logic [CNT_W-1:0]  convCnt;
  logic [SLIP_W-1:0] slipCnt;
  logic              slipNow, advance, lastCycle, lowSeen;

  always_comb begin
    slipNow   = (state == SEQ_CONV) && hostSlip && (slipCnt != SLIP_CAP);
    advance   = (state == SEQ_CONV) && !slipNow;
    lastCycle = advance && (convCnt == LAST_CNT);
    lowSeen   = !sLvl && (sPrev || (lowCnt != '0));

    strobes.capture = (state == SEQ_ARM) && sLvl;
    strobes.step    = advance && (convCnt >= FIRST_STEP);
    strobes.finish  = lastCycle;

    stateNext = state;
    unique case (state)
      SEQ_IDLE: if (lowSeen && (lowCnt == LOW_QUAL)) stateNext = SEQ_ARM;
      SEQ_ARM:  if (sLvl) stateNext = SEQ_CONV;
      SEQ_CONV: if (lastCycle) stateNext = SEQ_IDLE;
      default:  stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      lowCnt  <= '0;
      convCnt <= '0;
      slipCnt <= '0;
      overrun <= 1'b0;
    end else begin
      state <= stateNext;

      if (state == SEQ_IDLE && lowSeen && lowCnt != LOW_QUAL) lowCnt <= lowCnt + 1'b1;
      else lowCnt <= '0;

      if (state == SEQ_CONV) begin
        if (advance) convCnt <= lastCycle ? '0 : convCnt + 1'b1;
        if (slipNow) slipCnt <= slipCnt + 1'b1;
      end else begin
        convCnt <= '0;
        slipCnt <= '0;
      end

      if (state == SEQ_CONV && fellEdge) overrun <= 1'b1;
      else if (statusRead)               overrun <= 1'b0;
    end
  end

  assign busyN  = (state != SEQ_ARM);
  assign holdEn = (state == SEQ_CONV);

  // hold-window length tracker for the length bound
  logic [LEN_W-1:0] holdLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       holdLen <= '0;
    else if (holdEn) holdLen <= holdLen + 1'b1;
    else             holdLen <= '0;
  end

  a_r3_busy_hold_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!busyN && holdEn));

  a_r5_length_bound: assert property (@(posedge clk) disable iff (!rstN)
    holdEn |-> (holdLen <= LEN_LAST));

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !statusRead) |=> overrun);

  a_r1_hold_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEn) |-> $past(!busyN));

endmodule

// File: rtl/adc_sar_path.sv
module adc_sar_path
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  seqStrobes_t       strobes,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] heldSample, sarReg, bitPtr, trial, sarNext;

  always_comb begin
    trial   = sarReg | bitPtr;
    sarNext = (trial <= heldSample) ? trial : sarReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldSample <= '0;
      sarReg     <= '0;
      bitPtr     <= '0;
      done       <= 1'b0;
      result     <= '0;
    end else begin
      if (strobes.capture) begin
        heldSample <= sampleIn;
        sarReg     <= '0;
        bitPtr     <= MSB_MASK;
      end else if (strobes.step) begin
        sarReg <= sarNext;
        bitPtr <= bitPtr >> 1;
      end
      done <= strobes.finish;
      if (strobes.finish) result <= sarNext;
    end
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_finish_on_lsb: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |-> (bitPtr == DATA_W'(1)));

  a_r6_ptr_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bitPtr));

  a_r7_sample_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(heldSample));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CLKS   = 56,
  parameter int MAX_SLIP    = 17,
  parameter int MIN_LOW     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startN,
  input  logic              hostSlip,
  input  logic              statusRead,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              busyN,
  output logic              holdEn,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              overrun
);

  seqStrobes_t strobes;

  adc_seq_ctrl #(
    .DATA_W(DATA_W), .CONV_CLKS(CONV_CLKS), .MAX_SLIP(MAX_SLIP),
    .MIN_LOW(MIN_LOW), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startN(startN), .hostSlip(hostSlip),
    .statusRead(statusRead), .busyN(busyN), .holdEn(holdEn),
    .overrun(overrun), .strobes(strobes)
  );

  adc_sar_path #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .strobes(strobes),
    .done(done), .result(result)
  );

endmodule

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;

  localparam int NOM   = 56;
  localparam int SLIPS = 17;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startN = 1'b1;
  logic hostSlip = 1'b0;
  logic statusRead = 1'b0;
  logic [11:0] sampleIn = '0;
  logic busyN, holdEn, done, overrun;
  logic [11:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  adc_conv_seq u_dut (
    .clk(clk), .rstN(rstN), .startN(startN), .hostSlip(hostSlip),
    .statusRead(statusRead), .sampleIn(sampleIn), .busyN(busyN),
    .holdEn(holdEn), .done(done), .result(result), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit slipAt(input int pat, input int k);
    case (pat)
      1: return (k % 3) == 0;
      2: return 1'b1;
      3: return k <= 20;
      default: return 1'b0;
    endcase
  endfunction

  // inject: 0 none, 1 short start pulse during hold, 2 start held low past the end
  task automatic runConv(input int smp, input int pat, input int lowCycles, input int inject);
    int n, len, slips, expLen;
    sampleIn = 12'(smp);
    @(negedge clk);
    startN = 1'b0;
    hostSlip = (pat != 0);            // R5: ignored outside hold
    repeat (lowCycles) @(negedge clk);
    if (lowCycles >= 4) chk(busyN == 1'b0, "R3 busy low while start held", int'(busyN), 0);
    startN = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!holdEn && n < 20);
    chk(n == 3, "R1 release-to-hold latency", n, 3);
    chk(busyN == 1'b1, "R3 busy high during hold", int'(busyN), 1);
    len = 0;
    slips = 0;
    while (holdEn && len < 200) begin
      len++;
      if (len == 2) sampleIn = ~sampleIn;     // R7: must not matter
      if (inject != 0 && len == 10) startN = 1'b0;
      if (inject == 1 && len == 13) startN = 1'b1;
      hostSlip = slipAt(pat, len);
      if (hostSlip) slips++;
      @(negedge clk);
    end
    hostSlip = 1'b0;
    expLen = NOM + ((slips > SLIPS) ? SLIPS : slips);
    if (slips == 0) chk(len == expLen, "R4 nominal length", len, expLen);
    else            chk(len == expLen, "R5 slipped length", len, expLen);
    chk(done == 1'b1, "R6 done after hold", int'(done), 1);
    chk(result == 12'(smp), "R6 R7 result equals captured sample", int'(result), smp);
    @(negedge clk);
    chk(done == 1'b0, "R6 done single pulse", int'(done), 0);
    chk(result == 12'(smp), "R6 result held", int'(result), smp);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : main
    int seen;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busyN == 1'b1, "R10 busyN in reset", int'(busyN), 1);
    chk(holdEn == 1'b0, "R10 holdEn in reset", int'(holdEn), 0);
    chk(done == 1'b0, "R10 done in reset", int'(done), 0);
    chk(result == 12'd0, "R10 result in reset", int'(result), 0);
    chk(overrun == 1'b0, "R10 overrun in reset", int'(overrun), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2: one-clock pulse rejected
    startN = 1'b0;
    @(negedge clk);
    startN = 1'b1;
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (holdEn || !busyN) seen++;
    end
    chk(seen == 0, "R2 short pulse rejected", seen, 0);

    // R2: minimum pulse accepted, corners and sweep
    runConv(0, 0, 2, 0);
    runConv(4095, 0, 3, 0);
    runConv(2048, 2, 4, 0);
    runConv(2047, 3, 5, 0);
    for (int i = 0; i < 16; i++) begin
      runConv((i * 273 + 5 * i * i + 1) % 4096, i % 4, 2 + (i % 4), 0);
      chk(overrun == 1'b0, "R8 no overrun without stray start", int'(overrun), 0);
    end

    // R8: short stray start during hold
    runConv(12'h5A5, 1, 3, 1);
    chk(overrun == 1'b1, "R8 overrun set", int'(overrun), 1);
    repeat (4) @(negedge clk);
    chk(overrun == 1'b1, "R8 overrun sticky", int'(overrun), 1);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    chk(overrun == 1'b0, "R8 status read clears", int'(overrun), 0);

    // R9: start held low across the end of the conversion
    runConv(12'hA5A, 0, 2, 2);
    chk(overrun == 1'b1, "R8 overrun from held start", int'(overrun), 1);
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (holdEn || !busyN) seen++;
    end
    chk(seen == 0, "R9 held-low start does not restart", seen, 0);
    startN = 1'b1;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (holdEn || !busyN) seen++;
    end
    chk(seen == 0, "R9 release alone does not start", seen, 0);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    chk(overrun == 1'b0, "R8 clear after held start", int'(overrun), 0);

    // fresh start after R9 case works
    runConv(12'h123, 0, 2, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule